// File: doc/BRIEF.md
# Key-Generation Engine Register Interface

This block is the software-facing front end of a key-generation engine. A host on a simple 32-bit register bus selects one of four operating modes: enrolment, regeneration, authentication or random-number output. It starts the engine, polls for completion and moves data in and out. The engine itself sits outside this block. It sees a one-cycle start pulse with the selected mode, reads the parameter words the host loaded, writes result words and owns the helper-data memory while it runs. When it finishes, it returns a one-cycle done pulse.

All bulk data moves through address/data register pairs, so the bus never reaches a store directly. The first pair loads parameter words into a small array. The second pair reads result words back from a second array. The third reaches a 512-word by 32-bit helper-data memory. After enrolment the host reads the helper words back from that memory and keeps them in open storage. Before regeneration it writes them back. Each access to either helper data register advances the helper address by one, so a block transfer needs one address write and then one data access per word. While the engine runs, the host cannot disturb the engine's inputs. Data writes are dropped and flagged in an error bit, and control writes are dropped.

Top module: `keygen_regif`

## Requirements
- R1: After reset, the control register, the status register and all three address registers read as zero.
- R2: A write to the control register (byte offset 0x00) with bit 0 set, while idle, produces exactly one cycle of `eng_start`. In that cycle `eng_mode` equals bits 2:1 of the written word (0 enrol, 1 regenerate, 2 authenticate, 3 random). A later read of the control register returns the mode in bits 2:1 and 0 in bit 0.
- R3: The status register (offset 0x04) has busy in bit 0 and done in bit 1. Busy is set in the cycle of `eng_start` and clears one cycle after `eng_done`. Done is set at the same edge that clears busy and stays set until the next start.
- R4: A write to the parameter data register (0x0C) stores the word at the index held in the parameter address register (0x08). The engine reads it on `eng_prm_rdata` one cycle after presenting the index on `eng_prm_addr`.
- R5: A read of the result data register (0x14) returns the word that the engine last wrote at the index held in the result address register (0x10).
- R6: A write to the helper write-data register (0x1C) stores the word at the helper address (0x18) and then adds one to that address. A read of the helper read-data register (0x20) returns the word at the helper address and then adds one. The address wraps from 511 to 0.
- R7: While busy, writes to the parameter data or helper write-data registers are ignored and set the error bit (status bit 2). Helper read-data reads return 0 and do not advance the address. The error bit clears at the next start.
- R8: While busy, the engine's helper port (`eng_hlp_*`) reads and writes the helper memory. Words the engine writes there can be read over the bus once it is idle.
- R9: Read data appears on `bus_rdata` in the cycle after the cycle in which `bus_rd` is high.
- R10: While busy, writes to the control register are ignored: the mode is kept and no start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | BUS_AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_mode | output | 2 | Selected operating mode |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_prm_addr | input | PRM_AW | Engine parameter read index |
| eng_prm_rdata | output | 32 | Parameter word, one cycle after the index |
| eng_res_we | input | 1 | Engine result write enable |
| eng_res_addr | input | RES_AW | Engine result write index |
| eng_res_wdata | input | 32 | Engine result write data |
| eng_hlp_we | input | 1 | Engine helper memory write enable |
| eng_hlp_addr | input | HLP_AW | Engine helper memory address |
| eng_hlp_wdata | input | 32 | Engine helper memory write data |
| eng_hlp_rdata | output | 32 | Helper memory read data |

## Verification
The hardest condition to reach from the ports is a bus access that arrives while the engine is mid-run. The bench stands in for the engine, so it holds the run open for as long as it likes. During that window it issues dropped writes, a blocked helper read and a second start. Once the engine finishes, it checks that the parameter word, the helper word and the helper address are unchanged. Address wrap-around is reached by a full 512-word auto-increment sweep in each direction, and by a single access started at address 511.

// File: rtl/keygen_regif_pkg.sv
// Package: shared types for the key-generation register interface.
// Assumes a 32-bit data path and word-aligned byte addresses.
package keygen_regif_pkg;

    localparam int KG_DW = 32;

    // Operating modes as seen by the engine.
    typedef enum logic [1:0] {
        MODE_ENROLL = 2'd0,
        MODE_REGEN  = 2'd1,
        MODE_AUTH   = 2'd2,
        MODE_RNG    = 2'd3
    } kg_mode_e;

    // Word index of each register (byte offset divided by four).
    typedef enum logic [3:0] {
        REG_CTRL      = 4'd0,
        REG_STAT      = 4'd1,
        REG_PIN_ADDR  = 4'd2,
        REG_PIN_DATA  = 4'd3,
        REG_ROUT_ADDR = 4'd4,
        REG_ROUT_DATA = 4'd5,
        REG_HLP_ADDR  = 4'd6,
        REG_HLP_WDATA = 4'd7,
        REG_HLP_RDATA = 4'd8
    } kg_reg_e;

    // Source of the read data in the cycle after a read.
    typedef enum logic [1:0] {
        RSEL_ZERO = 2'd0,
        RSEL_CSR  = 2'd1,
        RSEL_RES  = 2'd2,
        RSEL_HLP  = 2'd3
    } kg_rsel_e;

endpackage

// File: rtl/kg_sdpram.sv
// Module: simple dual-port memory with one write port and one registered read port.
// Assumes a single clock. Reading and writing the same index in one cycle
// returns the old word.
module kg_sdpram #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/kg_spram.sv
// Module: single-port memory that reads its address every cycle.
// Assumes read-first behaviour: a write returns the old word on rdata.
module kg_spram #(
    parameter int DEPTH = 512,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Combined read and write port.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end

endmodule

// File: rtl/kg_ctrl_fsm.sv
// Module: run-state tracker for the engine: start pulse, busy, done and error.
// Assumes eng_done is a single-cycle pulse that arrives only while busy.
module kg_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic req_start,
    input  logic blocked_wr,
    input  logic eng_done,
    output logic start_pulse,
    output logic busy,
    output logic done,
    output logic err
);

    logic go;

    // A start request is taken only while idle.
    assign go = req_start && !busy;

    // Start pulse lasts for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) start_pulse <= 1'b0;
        else        start_pulse <= go;
    end

    // Busy runs from the start to the engine's completion.
    always_ff @(posedge clk) begin
        if (!rst_n)              busy <= 1'b0;
        else if (go)             busy <= 1'b1;
        else if (eng_done)       busy <= 1'b0;
    end

    // Done is set at completion and cleared by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)              done <= 1'b0;
        else if (go)             done <= 1'b0;
        else if (eng_done && busy) done <= 1'b1;
    end

    // Error is set by a blocked data write and cleared by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)              err <= 1'b0;
        else if (go)             err <= 1'b0;
        else if (blocked_wr)     err <= 1'b1;
    end

endmodule

// File: rtl/keygen_regif.sv
// Module: register interface for a key-generation engine. It decodes the
// register bus, holds mode and address registers, and routes indirect accesses
// to the parameter array, the result array and the helper-data memory.
// Assumes bus_wr and bus_rd are never high together, and byte addresses are
// word aligned.
module keygen_regif
    import keygen_regif_pkg::*;
#(
    parameter int BUS_AW    = 6,
    parameter int PRM_DEPTH = 16,
    parameter int RES_DEPTH = 16,
    parameter int HLP_DEPTH = 512,
    localparam int PRM_AW   = $clog2(PRM_DEPTH),
    localparam int RES_AW   = $clog2(RES_DEPTH),
    localparam int HLP_AW   = $clog2(HLP_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eng_start,
    output logic [1:0]        eng_mode,
    input  logic              eng_done,
    input  logic [PRM_AW-1:0] eng_prm_addr,
    output logic [31:0]       eng_prm_rdata,
    input  logic              eng_res_we,
    input  logic [RES_AW-1:0] eng_res_addr,
    input  logic [31:0]       eng_res_wdata,
    input  logic              eng_hlp_we,
    input  logic [HLP_AW-1:0] eng_hlp_addr,
    input  logic [31:0]       eng_hlp_wdata,
    output logic [31:0]       eng_hlp_rdata
);

    logic [3:0]        reg_idx;
    logic              busy_w, done_w, err_w;
    logic              wr_ctrl, wr_pin, wr_hlp, rd_hlp, rd_res;
    logic              req_start, blocked_wr;
    kg_mode_e          mode_q;
    logic [PRM_AW-1:0] pin_addr_q;
    logic [RES_AW-1:0] rout_addr_q;
    logic [HLP_AW-1:0] hlp_addr_q;
    kg_rsel_e          rsel_q;
    logic [31:0]       csr_q;
    logic [31:0]       res_rdata, hlp_rdata;
    logic              mem_we;
    logic [HLP_AW-1:0] mem_addr;
    logic [31:0]       mem_wdata;

    // Register word index from the byte address.
    assign reg_idx = bus_addr[5:2];

    // Decoded bus strobes.
    assign wr_ctrl    = bus_wr && (reg_idx == REG_CTRL);
    assign wr_pin     = bus_wr && (reg_idx == REG_PIN_DATA);
    assign wr_hlp     = bus_wr && (reg_idx == REG_HLP_WDATA);
    assign rd_hlp     = bus_rd && (reg_idx == REG_HLP_RDATA);
    assign rd_res     = bus_rd && (reg_idx == REG_ROUT_DATA);
    assign req_start  = wr_ctrl && bus_wdata[0];
    assign blocked_wr = busy_w && (wr_pin || wr_hlp);

    kg_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_start  (req_start),
        .blocked_wr (blocked_wr),
        .eng_done   (eng_done),
        .start_pulse(eng_start),
        .busy       (busy_w),
        .done       (done_w),
        .err        (err_w)
    );

    assign eng_mode = mode_q;

    // Mode register: takes any control write made while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mode_q <= MODE_ENROLL;
        else if (wr_ctrl && !busy_w) mode_q <= kg_mode_e'(bus_wdata[2:1]);
    end

    // Parameter and result address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_addr_q  <= '0;
            rout_addr_q <= '0;
        end else if (bus_wr) begin
            if (reg_idx == REG_PIN_ADDR)  pin_addr_q  <= bus_wdata[PRM_AW-1:0];
            if (reg_idx == REG_ROUT_ADDR) rout_addr_q <= bus_wdata[RES_AW-1:0];
        end
    end

    // Helper address: loaded directly, or stepped by an idle data access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hlp_addr_q <= '0;
        else if (bus_wr && reg_idx == REG_HLP_ADDR)
            hlp_addr_q <= bus_wdata[HLP_AW-1:0];
        else if ((wr_hlp || rd_hlp) && !busy_w)
            hlp_addr_q <= hlp_addr_q + 1'b1;
    end

    // Read path: register the source select and the control/status value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsel_q <= RSEL_ZERO;
            csr_q  <= '0;
        end else begin
            rsel_q <= RSEL_ZERO;
            csr_q  <= '0;
            if (bus_rd) begin
                rsel_q <= RSEL_CSR;
                case (reg_idx)
                    REG_CTRL:      csr_q <= {29'd0, mode_q, 1'b0};
                    REG_STAT:      csr_q <= {29'd0, err_w, done_w, busy_w};
                    REG_PIN_ADDR:  csr_q <= {{(32-PRM_AW){1'b0}}, pin_addr_q};
                    REG_ROUT_ADDR: csr_q <= {{(32-RES_AW){1'b0}}, rout_addr_q};
                    REG_HLP_ADDR:  csr_q <= {{(32-HLP_AW){1'b0}}, hlp_addr_q};
                    REG_ROUT_DATA: rsel_q <= RSEL_RES;
                    REG_HLP_RDATA: rsel_q <= busy_w ? RSEL_ZERO : RSEL_HLP;
                    default:       rsel_q <= RSEL_ZERO;
                endcase
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        case (rsel_q)
            RSEL_CSR: bus_rdata = csr_q;
            RSEL_RES: bus_rdata = res_rdata;
            RSEL_HLP: bus_rdata = hlp_rdata;
            default:  bus_rdata = '0;
        endcase
    end

    kg_sdpram #(.DEPTH(PRM_DEPTH), .DW(KG_DW)) u_prm (
        .clk   (clk),
        .we    (wr_pin && !busy_w),
        .waddr (pin_addr_q),
        .wdata (bus_wdata),
        .re    (1'b1),
        .raddr (eng_prm_addr),
        .rdata (eng_prm_rdata)
    );

    kg_sdpram #(.DEPTH(RES_DEPTH), .DW(KG_DW)) u_res (
        .clk   (clk),
        .we    (eng_res_we && busy_w),
        .waddr (eng_res_addr),
        .wdata (eng_res_wdata),
        .re    (rd_res),
        .raddr (rout_addr_q),
        .rdata (res_rdata)
    );

    // Helper memory port ownership: engine while busy, bus while idle.
    always_comb begin
        if (busy_w) begin
            mem_we    = eng_hlp_we;
            mem_addr  = eng_hlp_addr;
            mem_wdata = eng_hlp_wdata;
        end else begin
            mem_we    = wr_hlp;
            mem_addr  = hlp_addr_q;
            mem_wdata = bus_wdata;
        end
    end

    kg_spram #(.DEPTH(HLP_DEPTH), .DW(KG_DW)) u_hlp (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (hlp_rdata)
    );

    assign eng_hlp_rdata = hlp_rdata;

endmodule

// File: rtl/keygen_regif_chk.sv
// Module: property checker for keygen_regif, attached by bind.
// Assumes the bound signals are the top's run state and helper address.
module keygen_regif_chk #(
    parameter int HLP_AW = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [3:0]        reg_idx,
    input logic              eng_start,
    input logic              eng_done,
    input logic [1:0]        eng_mode,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [HLP_AW-1:0] hlp_addr
);

    // R2: the start pulse never lasts two cycles.
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R3: busy is already high in the start cycle.
    assert_busy_with_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);

    // R3: completion ends busy and raises done.
    assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && !eng_start) |=> (!busy && done));

    // R7: a data write while busy raises the error bit.
    assert_blocked_write_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && (reg_idx == 4'd3 || reg_idx == 4'd7)) |=> err);

    // R7: a helper read while busy leaves the helper address alone.
    assert_busy_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_rd && reg_idx == 4'd8) |=> $stable(hlp_addr));

    // R6: an idle helper write steps the helper address by one.
    assert_hlp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_wr && reg_idx == 4'd7) |=> (hlp_addr == $past(hlp_addr) + 1'b1));

    // R10: the mode does not move during a run.
    assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(eng_mode));

endmodule

bind keygen_regif keygen_regif_chk #(.HLP_AW(HLP_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .reg_idx   (reg_idx),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .eng_mode  (eng_mode),
    .busy      (busy_w),
    .done      (done_w),
    .err       (err_w),
    .hlp_addr  (hlp_addr_q)
);

// File: tb/tb_keygen_regif.sv
`timescale 1ns/1ps
// Bench: drives the register bus and stands in for the engine.
module tb_keygen_regif;

    localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_PADDR = 6'h08,
                           A_PDATA = 6'h0C, A_RADDR = 6'h10, A_RDATA = 6'h14,
                           A_HADDR = 6'h18, A_HWDATA = 6'h1C, A_HRDATA = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        eng_start, eng_done = 1'b0;
    logic [1:0]  eng_mode;
    logic [3:0]  eng_prm_addr = '0;
    logic [31:0] eng_prm_rdata;
    logic        eng_res_we = 1'b0;
    logic [3:0]  eng_res_addr = '0;
    logic [31:0] eng_res_wdata = '0;
    logic        eng_hlp_we = 1'b0;
    logic [8:0]  eng_hlp_addr = '0;
    logic [31:0] eng_hlp_wdata = '0, eng_hlp_rdata;

    int nvec = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    keygen_regif dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_mode(eng_mode), .eng_done(eng_done),
        .eng_prm_addr(eng_prm_addr), .eng_prm_rdata(eng_prm_rdata),
        .eng_res_we(eng_res_we), .eng_res_addr(eng_res_addr), .eng_res_wdata(eng_res_wdata),
        .eng_hlp_we(eng_hlp_we), .eng_hlp_addr(eng_hlp_addr), .eng_hlp_wdata(eng_hlp_wdata),
        .eng_hlp_rdata(eng_hlp_rdata)
    );

    function automatic logic [31:0] pval(input int i);
        return (i + 1) * 32'h0101_0F3B ^ 32'hA500_0000;
    endfunction

    function automatic logic [31:0] hval(input int i);
        return i * 32'h9E37_79B1 ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] rval(input int m, input int i);
        return pval(i) ^ (32'(m) << 28) ^ 32'(i * 3);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); d = bus_rdata; bus_rd = 1'b0;
    endtask

    task automatic prm_read(input int i, output logic [31:0] v);
        @(negedge clk); eng_prm_addr = 4'(i);
        @(negedge clk); v = eng_prm_rdata;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not end act=hung exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values.
        bus_read(A_STAT, v);  chk("R1 status", v, 32'h0);
        bus_read(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
        bus_read(A_PADDR, v); chk("R1 param addr", v, 32'h0);
        bus_read(A_RADDR, v); chk("R1 result addr", v, 32'h0);
        bus_read(A_HADDR, v); chk("R1 helper addr", v, 32'h0);

        // R4: load every parameter word and read it on the engine port.
        for (int i = 0; i < 16; i++) begin
            bus_write(A_PADDR, 32'(i));
            bus_write(A_PDATA, pval(i));
        end
        bus_read(A_PADDR, v); chk("R9 param addr readback", v, 32'd15);
        for (int i = 0; i < 16; i++) begin
            prm_read(i, v); chk("R4 param word", v, pval(i));
        end

        // R6: full helper sweep, write then read, with wrap back to zero.
        bus_write(A_HADDR, 32'd0);
        for (int i = 0; i < 512; i++) bus_write(A_HWDATA, hval(i));
        bus_read(A_HADDR, v); chk("R6 addr wrap after writes", v, 32'd0);
        for (int i = 0; i < 512; i++) begin
            bus_read(A_HRDATA, v); chk("R6 helper word", v, hval(i));
        end
        bus_read(A_HADDR, v); chk("R6 addr wrap after reads", v, 32'd0);
        bus_write(A_HADDR, 32'd511);
        bus_write(A_HWDATA, 32'hC0FF_EE11);
        bus_read(A_HADDR, v); chk("R6 wrap from 511", v, 32'd0);
        bus_write(A_HADDR, 32'd511);
        bus_read(A_HRDATA, v); chk("R6 word at 511", v, 32'hC0FF_EE11);
        bus_read(A_HADDR, v); chk("R6 read wrap from 511", v, 32'd0);

        // Every mode: start, blocked accesses, engine work, completion.
        for (int m = 0; m < 4; m++) begin
            bus_write(A_HADDR, 32'd200);
            bus_write(A_CTRL, (32'(m) << 1) | 32'd1);
            chk("R2 start pulse", {31'd0, eng_start}, 32'd1);
            chk("R2 mode to engine", {30'd0, eng_mode}, 32'(m));
            @(negedge clk);
            chk("R2 start one cycle", {31'd0, eng_start}, 32'd0);
            bus_read(A_STAT, v); chk("R3 busy, done and error cleared", v, 32'h1);
            bus_read(A_CTRL, v); chk("R2 ctrl readback", v, 32'(m) << 1);

            // R7 / R10: accesses during the run.
            bus_write(A_PADDR, 32'd0);
            bus_write(A_PDATA, 32'hDEAD_BEEF);
            bus_write(A_HWDATA, 32'hBAD0_BAD0);
            bus_read(A_HRDATA, v); chk("R7 helper read while busy", v, 32'h0);
            bus_write(A_CTRL, (32'(3 - m) << 1) | 32'd1);
            chk("R10 no start while busy", {31'd0, eng_start}, 32'd0);
            bus_read(A_STAT, v); chk("R7 error set while busy", v, 32'h5);

            // Engine stub work.
            for (int i = 0; i < 4; i++) begin
                prm_read(i, p);
                chk("R7 param kept", p, pval(i));
                @(negedge clk);
                eng_res_we = 1'b1; eng_res_addr = 4'(i); eng_res_wdata = rval(m, i);
                if (m == 0) begin
                    eng_hlp_we = 1'b1; eng_hlp_addr = 9'(100 + i); eng_hlp_wdata = ~p;
                end else begin
                    eng_hlp_addr = 9'(100 + i);
                end
                @(negedge clk);
                eng_res_we = 1'b0; eng_hlp_we = 1'b0;
                if (m != 0) begin
                    @(negedge clk);
                    chk("R8 engine reads helper", eng_hlp_rdata, ~pval(i));
                end
            end
            @(negedge clk); eng_done = 1'b1;
            @(negedge clk); eng_done = 1'b0;
            bus_read(A_STAT, v); chk("R3 done after completion", v, 32'h6);
            bus_read(A_CTRL, v); chk("R10 mode kept", v, 32'(m) << 1);
            bus_read(A_HADDR, v); chk("R7 helper addr kept", v, 32'd200);
            bus_read(A_HRDATA, v); chk("R7 helper word kept", v, hval(200));
            for (int i = 0; i < 4; i++) begin
                bus_write(A_RADDR, 32'(i));
                bus_read(A_RDATA, v); chk("R5 result word", v, rval(m, i));
            end
            bus_write(A_HADDR, 32'd100);
            for (int i = 0; i < 4; i++) begin
                bus_read(A_HRDATA, v); chk("R8 engine helper word", v, ~pval(i));
            end
        end

        // R4: an idle write after the runs still lands.
        bus_write(A_PADDR, 32'd5);
        bus_write(A_PDATA, 32'h1234_5678);
        prm_read(5, v); chk("R4 late param write", v, 32'h1234_5678);
        bus_read(A_STAT, v); chk("R3 done held while idle", v, 32'h6);

        finish_run();
    end

endmodule